// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Prescaler

This block derives the bit-rate timing for a synchronous serial master from its functional clock. Two counters are chained. The first divides the functional clock by a global ratio of 2, 4, 7 or 10, picked by a 2-bit index. The second divides the result again by a per-device ratio of 2, 4 or 8. The serial clock therefore runs at the functional clock divided by the product of the two ratios.

The output is a single-cycle tick at twice the serial clock rate, so a shift engine can toggle its serial clock line once per tick. Clearing the enable holds both counters idle and stops the ticks. Software chooses the ratios and can reload them at any time, for example each time a different device is selected. A new setting is adopted only when the first stage reaches its terminal count, so no period is ever cut short.

Top module: `sck_prescaler`

## Requirements
- R1: After reset `sck_tick` is low and stays low until `clk_en` is driven high.
- R2: `pre_sel` values 0, 1, 2 and 3 set the first-stage ratio to 2, 4, 7 and 10 functional clock cycles.
- R3: `post_sel` values 0, 1 and 2 set the second-stage ratio to 2, 4 and 8. Ticks then repeat every first-ratio × second-ratio / 2 cycles, which is twice the serial clock rate.
- R4: `post_sel` value 3 acts exactly like value 2, giving a second-stage ratio of 8.
- R5: While `clk_en` is low, no tick is produced. Once `clk_en` rises, the first tick follows exactly one tick period later, counted in rising edges with `clk_en` high, using the settings present at the rise.
- R6: A ratio change while running takes effect only at the next first-stage terminal count. The first-stage period already under way, and the tick decision made at its end, both use the old ratios.
- R7: `sck_tick` is high for one cycle only and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Prescaler enable; low holds both counters idle |
| pre_sel | input | 2 | Global first-stage ratio index |
| post_sel | input | 2 | Second-stage ratio code of the active device |
| sck_tick | output | 1 | One-cycle pulse at twice the serial clock rate |

## Verification
The bench measures the gap between successive ticks for every first-stage index and every second-stage code, including the duplicated code 3. A design with a wrong ratio table, or one that ignored the halving for the toggle rate, would report the wrong gap.

Ratios are also changed in the middle of a run, including one case where the second stage is partway through its count. A design that adopted the change at once would show a shortened or lengthened transitional gap. A design that compared the second-stage count with equality instead of a bound would hang until the count wrapped.

Enabling and disabling are exercised as well. This exposes stray ticks while disabled and an off-by-one first period after enable.

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int DIV_W = 4,
  parameter int SUB_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clk_en,
  input  logic [1:0] pre_sel,
  input  logic [1:0] post_sel,
  output logic       sck_tick
);

  function automatic logic [DIV_W-1:0] pre_ratio(input logic [1:0] s);
    case (s)
      2'd0:    pre_ratio = DIV_W'(2);
      2'd1:    pre_ratio = DIV_W'(4);
      2'd2:    pre_ratio = DIV_W'(7);
      default: pre_ratio = DIV_W'(10);
    endcase
  endfunction

  function automatic logic [SUB_W-1:0] half_ratio(input logic [1:0] c);
    case (c)
      2'd0:    half_ratio = SUB_W'(1);
      2'd1:    half_ratio = SUB_W'(2);
      default: half_ratio = SUB_W'(4);
    endcase
  endfunction

  logic [DIV_W-1:0] cnt1, act_r1;
  logic [SUB_W-1:0] cnt2, act_h;
  logic             term1, last2;

  assign term1 = (cnt1 == act_r1 - DIV_W'(1));
  assign last2 = ((cnt2 + SUB_W'(1)) >= act_h);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt1     <= '0;
      cnt2     <= '0;
      act_r1   <= DIV_W'(2);
      act_h    <= SUB_W'(1);
      sck_tick <= 1'b0;
    end else if (!clk_en) begin
      cnt1     <= '0;
      cnt2     <= '0;
      act_r1   <= pre_ratio(pre_sel);
      act_h    <= half_ratio(post_sel);
      sck_tick <= 1'b0;
    end else begin
      sck_tick <= 1'b0;
      if (term1) begin
        cnt1   <= '0;
        act_r1 <= pre_ratio(pre_sel);
        act_h  <= half_ratio(post_sel);
        if (last2) begin
          cnt2     <= '0;
          sck_tick <= 1'b1;
        end else begin
          cnt2 <= cnt2 + SUB_W'(1);
        end
      end else begin
        cnt1 <= cnt1 + DIV_W'(1);
      end
    end
  end

  // R5
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick |-> $past(clk_en));

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sck_tick |=> !sck_tick);

  // R6
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !term1) |=> ($stable(act_r1) && $stable(act_h)));

  // R2
  cnt1_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt1 < act_r1);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (!sck_tick && cnt1 == '0 && cnt2 == '0));

endmodule

// File: tb/test_sck_prescaler.sv
module test_sck_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic [1:0] pre_sel = 2'd0;
  logic [1:0] post_sel = 2'd0;
  logic       sck_tick;

  int n_chk = 0;
  int n_fail = 0;
  int exp_q[$];
  string tag_q[$];
  int gap = 0;
  bit done = 1'b0;

  sck_prescaler i_sck_prescaler (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
    .pre_sel(pre_sel), .post_sel(post_sel), .sck_tick(sck_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input string tag, input int p, input int n);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(p);
      tag_q.push_back(tag);
    end
  endtask

  // monitor: measures edges with clk_en high between ticks
  always @(posedge clk) begin
    #1;
    if (!rst_n || !clk_en) begin
      gap = 0;
    end else begin
      gap++;
      if (sck_tick) begin
        if (exp_q.size() == 0) begin
          check("R5_unexpected_tick", gap, 0);
        end else begin
          check(tag_q.pop_front(), gap, exp_q.pop_front());
        end
        gap = 0;
      end
    end
  end

  task automatic run_cfg(input string tag, input logic [1:0] ps, input logic [1:0] qs,
                         input int p);
    @(negedge clk);
    clk_en = 1'b0;
    pre_sel = ps;
    post_sel = qs;
    @(negedge clk);
    push(tag, p, 3);
    clk_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    clk_en = 1'b0;
  endtask

  task automatic mid_change(input string tag, input logic [1:0] ps0, input logic [1:0] qs0,
                            input logic [1:0] ps1, input logic [1:0] qs1,
                            input int p0, input int ptrans, input int p1);
    @(negedge clk);
    clk_en = 1'b0;
    pre_sel = ps0;
    post_sel = qs0;
    @(negedge clk);
    push(tag, p0, 2);
    push(tag, ptrans, 1);
    push(tag, p1, 2);
    clk_en = 1'b1;
    wait (exp_q.size() == 3);
    @(negedge clk);
    pre_sel = ps1;
    post_sel = qs1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    clk_en = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1_reset_tick", int'(sck_tick), 0);
    cnt = 0;
    repeat (10) begin @(negedge clk); cnt += int'(sck_tick); end
    check("R1_idle_after_reset", cnt, 0);

    // R2: first-stage ratios with second stage /2
    run_cfg("R2_idx0", 2'd0, 2'd0, 2);
    run_cfg("R2_idx1", 2'd1, 2'd0, 4);
    run_cfg("R2_idx2", 2'd2, 2'd0, 7);
    run_cfg("R2_idx3", 2'd3, 2'd0, 10);
    // R3: second-stage ratios
    run_cfg("R3_code1", 2'd1, 2'd1, 8);
    run_cfg("R3_code2", 2'd2, 2'd2, 28);
    run_cfg("R3_code2_idx3", 2'd3, 2'd2, 40);
    // R4: code 3 equals code 2
    run_cfg("R4_code3", 2'd3, 2'd3, 40);
    run_cfg("R4_code3_idx1", 2'd1, 2'd3, 16);

    // R5: disabled window produces no ticks
    @(negedge clk);
    clk_en = 1'b0;
    cnt = 0;
    repeat (40) begin @(negedge clk); cnt += int'(sck_tick); end
    check("R5_disabled_no_tick", cnt, 0);

    // R6: changes adopted at next first-stage terminal
    mid_change("R6_both", 2'd0, 2'd0, 2'd1, 2'd2, 2, 2, 16);
    mid_change("R6_post_only", 2'd3, 2'd0, 2'd3, 2'd1, 10, 10, 20);
    mid_change("R6_partial", 2'd0, 2'd2, 2'd0, 2'd0, 8, 4, 2);

    // R7: tick width and spacing at fastest setting
    @(negedge clk);
    pre_sel = 2'd0;
    post_sel = 2'd0;
    push("R7_fastest", 2, 6);
    clk_en = 1'b1;
    begin
      int prev = 0;
      int pairs = 0;
      repeat (12) begin
        @(negedge clk);
        if (prev == 1 && sck_tick) pairs++;
        prev = int'(sck_tick);
      end
      check("R7_no_back_to_back", pairs, 0);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
    clk_en = 1'b0;
    repeat (5) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule